// File: doc/BRIEF.md
# Dual-Source Reset Combiner

This block merges two independent external reset requests into one internal reset for a single clock domain. Either request on its own puts the domain into reset at once, and no clock edge is needed for that. The reset is only let go on a rising clock edge, so flops in the domain never see a release that is asynchronous to their clock.

Each request has its own synchronizer chain. The first edge of a request clears the chain asynchronously, and the chain then shifts out the inactive level on each clock. The outputs of the two chains are OR-merged. The merged signal sets one final release flop asynchronously, and that flop drives the internal reset. Any pulse on a request input is treated as a real reset request, even a pulse that falls between two clock edges. A two-bit sticky cause register records which sources took part in the most recent reset episode, and a clear strobe empties it once the sources are quiet.

The active level of the request inputs and of the reset output is set by one polarity parameter. The depth of the synchronizer chains is set by a stage-count parameter.

Top module: `rstc_top`

## Requirements
- R1: With `ACTIVE_LOW` = 1 (the default), a request input at 0 means "reset", and `rst_out` at 0 means the domain is in reset. With `ACTIVE_LOW` = 0, both levels are inverted.
- R2: `rst_out` goes active without any clock edge as soon as either request input goes active.
- R3: After the last active request goes inactive, `rst_out` stays active through N rising clock edges and goes inactive on the (N+1)-th edge. N is `SYNC_STAGES`, which defaults to 2 and must be at least 2.
- R4: While either request is still active, `rst_out` stays active, whatever the other request does.
- R5: A request pulse that begins and ends between two clock edges still produces a complete reset, which is released on the (N+1)-th edge after the pulse ends.
- R6: `cause` bit 0 stands for source A and bit 1 for source B. On the first clock edge of a new reset episode, `cause` is loaded with the set of sources whose synchronizers are active. A source that joins later in the same episode is ORed in. Outside an episode, `cause` holds its value.
- R7: `cause_clr` sampled high on an edge where neither synchronizer is active sets `cause` to 0. On an edge where a synchronizer is active, `cause_clr` is ignored.
- R8: After power-up with both requests active, `rst_out` is active and `cause` reads 2'b11 from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the reset domain |
| src_a_rst | input | 1 | Reset request A, asynchronous, level set by ACTIVE_LOW |
| src_b_rst | input | 1 | Reset request B, asynchronous, level set by ACTIVE_LOW |
| cause_clr | input | 1 | Clear strobe for the cause register, synchronous to clk |
| rst_out | output | 1 | Internal reset: asynchronous assertion, clocked release |
| cause | output | 2 | Sticky record of the sources in the latest reset episode |

## Verification
The bench drives request edges at random offsets between clock edges. It checks that the reset appears before any clock edge arrives; a design that waited for the clock would show a late assertion. It counts the edges to the release exactly, checking at N and at N+1, so an off-by-one chain, or a final stage that was left out, shows up as an early or a late release. It also runs overlapping requests released in either order, where a design that released on the first source to go away would fail. Sub-cycle glitches are sent as well, and a design that filtered them or missed the cause bit would show no reset or a wrong `cause`. Clear strobes are sent both while sources are quiet and while a request is held.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;
    localparam int NUM_SRC = 2;

    typedef logic [NUM_SRC-1:0] src_mask_t;

    // State of the sticky cause recorder
    typedef struct packed {
        logic      busy;   // a synchronizer was active at the previous edge
        src_mask_t cause;  // sources seen in the current or latest episode
    } cause_state_t;
endpackage

// File: rtl/rstc_sync_chain.sv
`timescale 1ns/1ps
// Per-source chain: forced active asynchronously, drained one stage per clock.
module rstc_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic src_act,
    output logic held
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b0};
    end

    always_ff @(posedge clk or posedge src_act) begin
        if (src_act) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign held = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_release_stage.sv
`timescale 1ns/1ps
// Final flop: set by the merged chains, cleared on the next clock after they drop.
module rstc_release_stage (
    input  logic clk,
    input  logic merged,
    output logic rst_act
);
    logic rel_d;
    logic rel_q;

    always_comb begin
        rel_d = 1'b0;
    end

    always_ff @(posedge clk or posedge merged) begin
        if (merged) rel_q <= 1'b1;
        else        rel_q <= rel_d;
    end

    assign rst_act = rel_q;
endmodule

// File: rtl/rstc_cause_reg.sv
`timescale 1ns/1ps
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic      clk,
    input  src_mask_t held,
    input  logic      clr,
    output src_mask_t cause
);
    cause_state_t st_d;
    cause_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = |held;
        if (|held) begin
            // new episode replaces, an ongoing one accumulates
            st_d.cause = held | (st_q.busy ? st_q.cause : '0);
        end else if (clr) begin
            st_d.cause = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cause = st_q.cause;
endmodule

// File: rtl/rstc_top.sv
`timescale 1ns/1ps
module rstc_top
    import rstc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic       clk,
    input  logic       src_a_rst,
    input  logic       src_b_rst,
    input  logic       cause_clr,
    output logic       rst_out,
    output logic [1:0] cause
);
    src_mask_t src_raw;
    src_mask_t src_act;
    src_mask_t held;
    logic      any_held;
    logic      rst_act;

    assign src_raw = {src_b_rst, src_a_rst};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (ACTIVE_LOW) begin : g_inv
            assign src_act[i] = ~src_raw[i];
        end else begin : g_pass
            assign src_act[i] = src_raw[i];
        end
        rstc_sync_chain #(.STAGES(SYNC_STAGES)) u_chain (
            .clk     (clk),
            .src_act (src_act[i]),
            .held    (held[i])
        );
    end

    assign any_held = |held;

    rstc_release_stage u_rel (
        .clk     (clk),
        .merged  (any_held),
        .rst_act (rst_act)
    );

    rstc_cause_reg u_cause (
        .clk   (clk),
        .held  (held),
        .clr   (cause_clr),
        .cause (cause)
    );

    if (ACTIVE_LOW) begin : g_out_inv
        assign rst_out = ~rst_act;
    end else begin : g_out_pass
        assign rst_out = rst_act;
    end
endmodule

// File: rtl/rstc_checker.sv
`timescale 1ns/1ps
module rstc_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic [1:0] req_act,
    input logic [1:0] held,
    input logic       merged,
    input logic       rst_act,
    input logic [1:0] cause,
    input logic       clr
);
    localparam int LAT = SYNC_STAGES + 1;
    localparam int CW  = $clog2(LAT + 1) + 1;

    logic          req_any;
    logic          armed_q;
    logic [CW-1:0] quiet_q;

    assign req_any = |req_act;

    // edges since the last request activity, saturating at LAT
    always_ff @(posedge clk or posedge req_any) begin
        if (req_any) begin
            armed_q <= 1'b1;
            quiet_q <= '0;
        end else begin
            armed_q <= armed_q;
            if (quiet_q < CW'(LAT)) quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_async_assert_R2: assert property (@(posedge clk) disable iff (!armed_q)
        req_any |-> rst_act);
    assert_release_latency_R3: assert property (@(posedge clk) disable iff (!armed_q)
        $fell(rst_act) |-> (quiet_q == CW'(LAT)));
    assert_no_early_release_R3: assert property (@(posedge clk) disable iff (!armed_q)
        !rst_act |-> (quiet_q == CW'(LAT)));
    assert_cause_covers_R6: assert property (@(posedge clk) disable iff (!armed_q)
        merged |=> ((cause & $past(held)) == $past(held)));
    assert_cause_hold_R6: assert property (@(posedge clk) disable iff (!armed_q)
        (!merged && !clr) |=> $stable(cause));
    assert_cause_clear_R7: assert property (@(posedge clk) disable iff (!armed_q)
        (!merged && clr) |=> (cause == 2'b00));
    assert_clear_ignored_R7: assert property (@(posedge clk) disable iff (!armed_q)
        (merged && clr) |=> (cause != 2'b00));
endmodule

bind rstc_top rstc_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk     (clk),
    .req_act (src_act),
    .held    (held),
    .merged  (any_held),
    .rst_act (rst_act),
    .cause   (cause),
    .clr     (cause_clr)
);

// File: tb/tb_rstc_top.sv
`timescale 1ns/1ps
module tb_rstc_top;
    localparam int N   = 2;
    localparam int LAT = N + 1;

    logic       clk = 1'b0;
    logic       a_n = 1'b1;
    logic       b_n = 1'b1;
    logic       clr = 1'b0;
    logic       rst_out;
    logic [1:0] cause;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rstc_top #(.SYNC_STAGES(N), .ACTIVE_LOW(1'b1)) dut (
        .clk       (clk),
        .src_a_rst (a_n),
        .src_b_rst (b_n),
        .cause_clr (clr),
        .rst_out   (rst_out),
        .cause     (cause)
    );

    // expected output level for "in reset" under the active-low default (R1)
    function automatic logic exp_rst(input bit in_reset);
        return in_reset ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic small_delay();
        #(0.001 * $urandom_range(100, 500));
    endtask

    // called just after the last request went inactive, between edges
    task automatic release_check(input string req);
        repeat (N) @(posedge clk);
        #1 chk({req, " held through N edges"}, {1'b0, rst_out}, {1'b0, exp_rst(1)});
        @(posedge clk);
        #1 chk({req, " released on edge N+1"}, {1'b0, rst_out}, {1'b0, exp_rst(0)});
    endtask

    task automatic set_src(input int s, input logic act);
        if (s == 0) a_n = ~act; else b_n = ~act;
    endtask

    // one reset episode: first source, optional second, both released in random order
    task automatic episode(input logic [1:0] mask, input bit glitch);
        int first;
        first = mask[0] ? 0 : 1;
        @(negedge clk); small_delay();
        set_src(first, 1'b1);
        #0.2 chk("R2 async assertion", {1'b0, rst_out}, {1'b0, exp_rst(1)});
        if (glitch && mask != 2'b11) begin
            #0.2 set_src(first, 1'b0);
            release_check("R5 glitch");
        end else begin
            repeat ($urandom_range(1, 5)) @(posedge clk);
            if (mask == 2'b11) begin
                int last;
                @(negedge clk); small_delay();
                set_src(1 - first, 1'b1);
                repeat ($urandom_range(1, 4)) @(posedge clk);
                last = ($urandom_range(0, 1) == 0) ? first : 1 - first;
                @(negedge clk);
                set_src(1 - last, 1'b0);
                repeat ($urandom_range(LAT, LAT + 3)) begin
                    @(posedge clk);
                    #1 chk("R4 held by remaining source", {1'b0, rst_out}, {1'b0, exp_rst(1)});
                end
                @(negedge clk); small_delay();
                set_src(last, 1'b0);
            end else begin
                @(negedge clk); small_delay();
                set_src(first, 1'b0);
            end
            release_check("R3");
        end
        chk("R6 cause of episode", cause, mask);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // power-up: both requests active (R8)
        #1 a_n = 1'b0; b_n = 1'b0;
        #0.5 chk("R8 reset at power-up", {1'b0, rst_out}, {1'b0, exp_rst(1)});
        repeat (3) @(posedge clk);
        #1 chk("R8 cause after power-up", cause, 2'b11);
        @(negedge clk); small_delay();
        a_n = 1'b1; b_n = 1'b1;
        release_check("R3 power-up");

        // clear while idle (R7)
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        chk("R7 clear while idle", cause, 2'b00);

        // directed glitch on B only (R5, R6)
        @(negedge clk); #0.1 b_n = 1'b0;
        #0.3 chk("R5 glitch asserts", {1'b0, rst_out}, {1'b0, exp_rst(1)});
        b_n = 1'b1;
        release_check("R5 glitch B");
        chk("R6 glitch cause", cause, 2'b10);

        // clear while a source is active is ignored (R7)
        @(negedge clk); small_delay(); a_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        chk("R7 clear ignored while active", cause, 2'b01);
        small_delay(); a_n = 1'b1;
        release_check("R3 after ignored clear");
        chk("R7 cause kept", cause, 2'b01);
        repeat (3) @(posedge clk);
        #1 chk("R6 cause holds when idle", cause, 2'b01);

        // directed overlap with both orders, then random episodes
        episode(2'b11, 1'b0);
        episode(2'b11, 1'b0);
        for (int k = 0; k < 40; k++) begin
            logic [1:0] m;
            m = 2'($urandom_range(1, 3));
            episode(m, $urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 1) begin
                @(negedge clk) clr = 1'b1;
                @(negedge clk) clr = 1'b0;
                chk("R7 random clear", cause, 2'b00);
            end
            repeat ($urandom_range(1, 3)) @(posedge clk);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #100000;
                fails++;
                $display("FAIL watchdog expired at %0t", $time);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule